// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This peripheral produces one pulse-width modulated output. Software sets it up through a 32-bit register bus. The length of each cycle comes from a period register. The high time of each cycle comes from duty samples, which software pushes into a four-deep queue. At each cycle boundary the modulator takes the next queued sample. Software can therefore stream a sequence of duty values without any cycle-exact timing on its side. A status register reports how many samples are waiting.

The counter does not run on the bus clock directly. It advances on prescaled ticks, which are derived from one of two tick-enable inputs chosen in the control register. A 12-bit divider sits between the chosen input and the counter. The control register also holds:
- the run enable,
- an output inversion bit,
- three flags that are only stored,
- a self-clearing soft-reset bit. Soft reset returns all programmable state to zero and empties the queue.

Top module: `pwm_queued`

## Requirements
- R1: Registers are decoded at byte offsets 0x00 (control), 0x04 (status), 0x0C (sample) and 0x10 (period). Control reads back only its implemented bits, so a write of 0xFFFFFFF7 reads back as 0x01C7FFF1. All registers read 0 after reset.
- R2: Control bit 0 runs the modulator. While it is 0, the prescaler and counter are held at zero and the output sits at its inactive level: 0, or 1 when inverted.
- R3: The 16-bit period register value plus 2 gives the cycle length in prescaled ticks. The output is high for the first S ticks of each cycle, where S is the active sample. It is high for the whole cycle when S is at least the cycle length.
- R4: Control bits 15:4 hold the divide ratio minus one. A field value of k gives one prescaled tick per k+1 selected source ticks.
- R5: Control bits 17:16 choose the tick source. Value 1 selects `src_tick_a` and value 2 selects `src_tick_b`. Values 0 and 3 select no source, and the output then freezes.
- R6: Control bit 18 inverts the output.
- R7: Control bits 22, 23 and 24 are plain read/write storage and do not affect the output.
- R8: Status bits 2:0 give the number of queued samples, from 0 to 4. A sample write while 4 are queued is dropped.
- R9: At each cycle boundary the oldest queued sample becomes active. When the queue is empty, the active sample is kept. When the modulator is enabled, the oldest queued sample is loaded at once and the output stays inactive for that one clock. The first cycle then starts.
- R10: Writing control with bit 3 set starts a soft reset. The soft reset clears control, period and the active sample and empties the queue. Bit 3 reads 1 for 4 clocks and then clears itself.
- R11: Bus writes that arrive while the soft reset is in progress are ignored.
- R12: A sample write that lands in the same clock as a cycle-boundary pop is accepted while the pop also takes place, so the queue level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1 (with bus_sel) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick_a | input | 1 | Tick enable of source 1 |
| src_tick_b | input | 1 | Tick enable of source 2 |
| pwm_out | output | 1 | Modulated output |

## Verification
Two events can fall in the same clock: a bus push into the queue and the cycle-boundary pop that loads the next sample. The bench provokes this by enabling the block with a period of 8 ticks and one tick per clock. It then counts clocks from the enable write and places a sample write exactly on the ninth clock edge, where the first boundary occurs. It judges the outcome from the status level, which must stay at 1, and from the high times of the following cycles.

// File: rtl/pwm_q_pkg.sv
`timescale 1ns/1ps
package pwm_q_pkg;
    // register byte offsets
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_SMPL = 8'h0C;
    localparam logic [7:0] OFF_PER  = 8'h10;
    // control bit positions
    localparam int B_EN     = 0;
    localparam int B_SWR    = 3;
    localparam int B_PRE_LO = 4;
    localparam int B_SRC_LO = 16;
    localparam int B_INV    = 18;
    localparam int B_DBG    = 22;
    localparam int B_WAIT   = 23;
    localparam int B_DOZE   = 24;
    // tick source codes
    localparam logic [1:0] SRC_A = 2'd1;
    localparam logic [1:0] SRC_B = 2'd2;
endpackage

// File: rtl/pwm_q_fifo.sv
`timescale 1ns/1ps
module pwm_q_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [LVL_W-1:0]        lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    assign full  = (st_q.lvl == LVL_W'(DEPTH));
    assign empty = (st_q.lvl == '0);
    assign level = st_q.lvl;
    assign head  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            end
            if (do_pop)
                st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.lvl = st_q.lvl + 1'b1;
                2'b01:   st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_q_prescale.sv
`timescale 1ns/1ps
module pwm_q_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_tick,
    input  logic [PRE_W-1:0] div_m1,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    assign tick = !clr && src_tick && (cnt_q >= div_m1);

    always_comb begin
        cnt_d = cnt_q;
        if (clr)           cnt_d = '0;
        else if (src_tick) cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwm_q_period.sv
`timescale 1ns/1ps
module pwm_q_period #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [PW-1:0] period,
    input  logic [PW-1:0] sample,
    output logic          roll,
    output logic          high
);
    localparam int CW = PW + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last_val;

    assign last_val = {1'b0, period} + CW'(1);
    assign roll     = !clr && tick && (cnt_q >= last_val);
    assign high     = cnt_q < {1'b0, sample};

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = roll ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwm_queued.sv
`timescale 1ns/1ps
module pwm_queued
    import pwm_q_pkg::*;
#(
    parameter int AW         = 5,
    parameter int DW         = 32,
    parameter int PW         = 16,
    parameter int PRE_W      = 12,
    parameter int DEPTH      = 4,
    parameter int SWR_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          src_tick_a,
    input  logic          src_tick_b,
    output logic          pwm_out
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int SC_W  = (SWR_CYCLES > 1) ? $clog2(SWR_CYCLES) : 1;

    typedef struct packed {
        logic             en;
        logic [PRE_W-1:0] pre;
        logic [1:0]       src;
        logic             inv;
        logic             dbg;
        logic             wt;
        logic             dz;
        logic             swr;
        logic [SC_W-1:0]  swr_cnt;
        logic [PW-1:0]    per;
        logic [PW-1:0]    act;
        logic             fresh;
    } st_t;

    st_t st_d, st_q;

    logic wr_any, wr_ctrl, wr_smp, wr_per, enter_rst;
    logic pop, run, src_tick, pre_tick, roll, high;
    logic fifo_full, fifo_empty;
    logic [PW-1:0]    fifo_head;
    logic [LVL_W-1:0] fifo_level;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign run = st_q.en && !st_q.fresh;

    always_comb begin
        case (st_q.src)
            SRC_A:   src_tick = src_tick_a;
            SRC_B:   src_tick = src_tick_b;
            default: src_tick = 1'b0;
        endcase
    end

    always_comb begin
        wr_any    = bus_sel && bus_we && !st_q.swr;
        wr_ctrl   = wr_any && (bus_addr == AW'(OFF_CTRL));
        wr_smp    = wr_any && (bus_addr == AW'(OFF_SMPL));
        wr_per    = wr_any && (bus_addr == AW'(OFF_PER));
        enter_rst = wr_ctrl && bus_wdata[B_SWR];
        pop       = !fifo_empty && ((st_q.en && st_q.fresh) || roll);

        st_d = st_q;
        if (st_q.swr) begin
            if (st_q.swr_cnt == '0) st_d.swr = 1'b0;
            else                    st_d.swr_cnt = st_q.swr_cnt - 1'b1;
        end else if (enter_rst) begin
            st_d         = '0;
            st_d.swr     = 1'b1;
            st_d.swr_cnt = SC_W'(SWR_CYCLES - 1);
            st_d.fresh   = 1'b1;
        end else begin
            if (wr_ctrl) begin
                st_d.en  = bus_wdata[B_EN];
                st_d.pre = bus_wdata[B_PRE_LO +: PRE_W];
                st_d.src = bus_wdata[B_SRC_LO +: 2];
                st_d.inv = bus_wdata[B_INV];
                st_d.dbg = bus_wdata[B_DBG];
                st_d.wt  = bus_wdata[B_WAIT];
                st_d.dz  = bus_wdata[B_DOZE];
            end
            if (wr_per) st_d.per = bus_wdata[PW-1:0];
            if (pop)    st_d.act = fifo_head;
            if (!st_q.en)        st_d.fresh = 1'b1;
            else if (st_q.fresh) st_d.fresh = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFF_CTRL): begin
                bus_rdata[B_EN]                = st_q.en;
                bus_rdata[B_SWR]               = st_q.swr;
                bus_rdata[B_PRE_LO +: PRE_W]   = st_q.pre;
                bus_rdata[B_SRC_LO +: 2]       = st_q.src;
                bus_rdata[B_INV]               = st_q.inv;
                bus_rdata[B_DBG]               = st_q.dbg;
                bus_rdata[B_WAIT]              = st_q.wt;
                bus_rdata[B_DOZE]              = st_q.dz;
            end
            AW'(OFF_STAT): bus_rdata[LVL_W-1:0] = fifo_level;
            AW'(OFF_SMPL): bus_rdata[PW-1:0]    = st_q.act;
            AW'(OFF_PER):  bus_rdata[PW-1:0]    = st_q.per;
            default:       bus_rdata = '0;
        endcase
    end

    assign pwm_out = st_q.inv ^ (run && high);

    pwm_q_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (enter_rst),
        .push  (wr_smp),
        .pop   (pop),
        .din   (bus_wdata[PW-1:0]),
        .head  (fifo_head),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwm_q_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!run),
        .src_tick (src_tick),
        .div_m1   (st_q.pre),
        .tick     (pre_tick)
    );

    pwm_q_period #(.PW(PW)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!run),
        .tick   (pre_tick),
        .period (st_q.per),
        .sample (st_q.act),
        .roll   (roll),
        .high   (high)
    );
endmodule

// File: rtl/pwm_queued_chk.sv
`timescale 1ns/1ps
module pwm_queued_chk #(
    parameter int AW         = 5,
    parameter int DEPTH      = 4,
    parameter int SWR_CYCLES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_we,
    input logic [AW-1:0]              bus_addr,
    input logic                       swr_busy,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level,
    input logic                       en_w,
    input logic                       inv_w,
    input logic                       run_w,
    input logic                       src_tick_w,
    input logic                       pop_w,
    input logic                       pwm_out
);
    int unsigned swr_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        swr_len <= 0;
        else if (swr_busy) swr_len <= swr_len + 1;
        else               swr_len <= 0;
    end

    // R10
    swr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swr_len <= SWR_CYCLES);

    // R10
    swr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swr_busy |-> (fifo_level == '0) && !en_w);

    // R8
    level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == AW'(8'h0C) && !swr_busy &&
         fifo_level == ($clog2(DEPTH+1))'(DEPTH) && !pop_w)
        |=> fifo_level == ($clog2(DEPTH+1))'(DEPTH));

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |-> pwm_out == inv_w);

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && !src_tick_w && !(bus_sel && bus_we)) |=> $stable(pwm_out));
endmodule

bind pwm_queued pwm_queued_chk #(
    .AW(AW), .DEPTH(DEPTH), .SWR_CYCLES(SWR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .swr_busy   (st_q.swr),
    .fifo_level (fifo_level),
    .en_w       (st_q.en),
    .inv_w      (st_q.inv),
    .run_w      (run),
    .src_tick_w (src_tick),
    .pop_w      (pop),
    .pwm_out    (pwm_out)
);

// File: tb/test_pwm_queued.sv
`timescale 1ns/1ps
module test_pwm_queued;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_SMPL = 5'h0C, A_PER = 5'h10;
    localparam logic [31:0] C_EN = 32'h1, C_SWR = 32'h8, C_SRC1 = 32'h1_0000,
                            C_SRC2 = 32'h2_0000, C_SRC3 = 32'h3_0000, C_INV = 32'h4_0000;

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] smp;
        logic [11:0] pre;
        logic        inv;
        logic [15:0] hi;
        logic [15:0] win;
    } vec_t;

    // per, sample, prescale field, invert, expected high clocks, window
    localparam vec_t VEC [7] = '{
        '{16'd6,  16'd3, 12'd0, 1'b0, 16'd3,  16'd8},
        '{16'd6,  16'd3, 12'd0, 1'b1, 16'd5,  16'd8},
        '{16'd0,  16'd1, 12'd0, 1'b0, 16'd1,  16'd2},
        '{16'd4,  16'd0, 12'd0, 1'b0, 16'd0,  16'd6},
        '{16'd4,  16'd9, 12'd0, 1'b0, 16'd6,  16'd6},
        '{16'd10, 16'd5, 12'd2, 1'b0, 16'd15, 16'd36},
        '{16'd2,  16'd4, 12'd3, 1'b1, 16'd0,  16'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic src_tick_a = 1'b1, src_tick_b = 1'b0;
    logic pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_queued i_pwm_queued (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick_a(src_tick_a), .src_tick_b(src_tick_b), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values and R2 idle output
        rd(A_CTRL, d); chk("R1 ctrl reset", d, 0);
        rd(A_STAT, d); chk("R8 status reset", d, 0);
        rd(A_PER, d);  chk("R1 period reset", d, 0);
        #1 chk("R2 idle out after reset", pwm_out, 0);

        // R1 implemented-bit mask
        wr(A_CTRL, 32'hFFFF_FFF7);
        rd(A_CTRL, d); chk("R1 ctrl mask", d, 32'h01C7_FFF1);
        wr(A_CTRL, 32'h0);
        // R7 stored-only flags
        wr(A_CTRL, 32'h01C0_0000);
        rd(A_CTRL, d); chk("R7 flag readback", d, 32'h01C0_0000);
        measure(8, hi); chk("R7 flags leave output low", hi, 0);
        wr(A_CTRL, 32'h0);

        // R3 R4 R6 vector table
        foreach (VEC[k]) begin
            wr(A_CTRL, 32'h0);
            wr(A_PER, {16'h0, VEC[k].per});
            wr(A_SMPL, {16'h0, VEC[k].smp});
            wr(A_CTRL, C_EN | C_SRC1 | {20'h0, VEC[k].pre} << 4 | (VEC[k].inv ? C_INV : 32'h0));
            repeat (2 * VEC[k].win + 4) @(negedge clk);
            measure(int'(VEC[k].win), hi);
            chk($sformatf("R3 R4 R6 vector %0d", k), hi, VEC[k].hi);
        end

        // R2 disabled with inversion holds high
        wr(A_CTRL, C_INV);
        measure(8, hi); chk("R2 disabled inverted level", hi, 8);
        wr(A_CTRL, 32'h0);
        measure(8, hi); chk("R2 disabled level", hi, 0);

        // R5 source selection
        wr(A_PER, 32'd6);
        wr(A_SMPL, 32'd3);
        wr(A_CTRL, C_EN | C_SRC1);
        repeat (20) @(negedge clk);
        measure(8, hi); chk("R5 source a runs", hi, 3);
        src_tick_a = 1'b0;
        measure(16, hi); chk("R5 no tick freezes", (hi == 0 || hi == 16), 1);
        src_tick_b = 1'b1;
        wr(A_CTRL, C_EN | C_SRC2);
        repeat (20) @(negedge clk);
        measure(8, hi); chk("R5 source b runs", hi, 3);
        src_tick_a = 1'b1;
        wr(A_CTRL, C_EN | C_SRC3);
        repeat (2) @(negedge clk);
        measure(16, hi); chk("R5 code 3 freezes", (hi == 0 || hi == 16), 1);
        src_tick_b = 1'b0;
        wr(A_CTRL, 32'h0);

        // R8 full queue drops, R9 ordering and reuse
        wr(A_SMPL, 32'd1); wr(A_SMPL, 32'd2); wr(A_SMPL, 32'd3);
        wr(A_SMPL, 32'd4); wr(A_SMPL, 32'd7);
        rd(A_STAT, d); chk("R8 full level", d, 4);
        wr(A_CTRL, C_EN | C_SRC1);
        #1 chk("R9 load clock inactive", pwm_out, 0);
        measure(8, hi); chk("R9 first sample", hi, 1);
        measure(8, hi); chk("R9 second sample", hi, 2);
        measure(8, hi); chk("R9 third sample", hi, 3);
        measure(8, hi); chk("R9 fourth sample", hi, 4);
        measure(8, hi); chk("R8 dropped write absent, R9 reuse", hi, 4);
        rd(A_STAT, d); chk("R9 queue drained", d, 0);

        // R12 push on the same edge as a boundary pop
        wr(A_CTRL, 32'h0);
        wr(A_SMPL, 32'd2); wr(A_SMPL, 32'd6);
        wr(A_CTRL, C_EN | C_SRC1);
        repeat (7) @(negedge clk);
        wr(A_SMPL, 32'd4);
        rd(A_STAT, d); chk("R12 level kept", d, 1);
        measure(8, hi); chk("R12 popped sample active", hi, 6);
        measure(8, hi); chk("R12 pushed sample next", hi, 4);

        // R10 soft reset, R11 writes ignored meanwhile
        wr(A_CTRL, 32'h0);
        wr(A_SMPL, 32'd5); wr(A_SMPL, 32'd5);
        rd(A_STAT, d); chk("R10 level before reset", d, 2);
        wr(A_PER, 32'd9);
        wr(A_CTRL, C_SWR | C_EN);
        rd(A_CTRL, d); chk("R10 reset bit reads one", d, 32'h8);
        wr(A_PER, 32'd3);
        repeat (4) @(negedge clk);
        rd(A_CTRL, d); chk("R10 reset bit self-clears", d, 0);
        rd(A_STAT, d); chk("R10 queue flushed", d, 0);
        rd(A_PER, d);  chk("R11 write during reset ignored", d, 0);
        rd(A_SMPL, d); chk("R10 active sample cleared", d, 0);
        wr(A_PER, 32'd6);
        wr(A_CTRL, C_EN | C_SRC1);
        repeat (20) @(negedge clk);
        measure(8, hi); chk("R10 zero duty after reset", hi, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule